// File: doc/BRIEF.md
# Memory-Mirror Transaction Responder

This block is a reduced transaction-layer endpoint that serves request packets from a local memory mirror. Requests arrive on a valid/ready channel. There are four request kinds: memory read, memory write, configuration read and configuration write. Completions leave on a second valid/ready channel.

- **Memory write:** the payload is stored in a byte-addressed memory, one 32-bit doubleword per accepted beat. No response is sent.
- **Memory read:** the block returns a data completion of one doubleword per beat. The completion echoes the request's tag, length and byte address, and raises a last flag on its final beat.
- **Configuration read:** answered with a single zero doubleword.
- **Configuration write:** accepted and discarded.

Read-type requests are queued in a small FIFO of pending reads, so completions come back in request order. A memory write is held off until every earlier read has finished, which means a read always sees memory as it stood when the read was accepted.

The memory holds 2^ADDR_W bytes as little-endian doublewords. Byte lane k of a stored doubleword belongs to byte address 4w+k. ADDR_W=16 gives the full 64 KB mirror; the default of 12 keeps elaboration small.

Top module: `mm_mirror_responder`

## Requirements
- R1: A memory write (req_type_i=1) stores its payload at consecutive doubleword addresses starting at req_addr_i, one doubleword per accepted beat. The first beat carries the header fields. A memory write produces no completion.
- R2: A memory read (req_type_i=0) yields exactly one completion. Each of its beats returns the next stored doubleword. Every beat carries the request's tag, length field and byte address. cpl_last_o is high on the final beat only.
- R3: A length field of 0 means 2^LEN_W doublewords (16 with defaults); any other value n means n doublewords.
- R4: Doubleword selection uses address bits [ADDR_W-1:2]. Higher address bits and bits [1:0] do not select storage, and a burst that runs past the top of memory wraps to doubleword 0. cpl_addr_o still echoes the full request address.
- R5: A configuration read (req_type_i=2) yields a single-beat completion. It has data 0, length field 1, cpl_last_o high and the request tag.
- R6: A configuration write (req_type_i=3) is accepted in one beat and leaves memory unchanged.
- R7: Completions leave in the order their requests were accepted.
- R8: cpl_status_o is 0 (successful) on every completion beat.
- R9: Once cpl_valid_o is high, it stays high and all completion fields stay stable until cpl_ready_i is seen.
- R10: Up to DEPTH pending reads are queued, plus one in service. A further read or configuration read is held off with req_ready_o low.
- R11: A memory write header is not accepted while any read is pending or in service.
- R12: After reset, cpl_valid_o is low and req_ready_o is high for a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request beat valid |
| req_ready_o | output | 1 | Request beat accepted when high with valid |
| req_type_i | input | 2 | 0 mem read, 1 mem write, 2 cfg read, 3 cfg write |
| req_addr_i | input | REQ_AW | Byte address |
| req_len_i | input | LEN_W | Length in doublewords, 0 = 2^LEN_W |
| req_tag_i | input | TAG_W | Requester tag |
| req_data_i | input | 32 | Write payload doubleword |
| cpl_valid_o | output | 1 | Completion beat valid |
| cpl_ready_i | input | 1 | Completion beat taken |
| cpl_tag_o | output | TAG_W | Echoed tag |
| cpl_len_o | output | LEN_W | Echoed length field |
| cpl_addr_o | output | REQ_AW | Echoed byte address |
| cpl_data_o | output | 32 | Completion payload doubleword |
| cpl_status_o | output | 3 | Completion status, 0 = successful |
| cpl_last_o | output | 1 | Final beat of completion |

## Verification
The bench builds the block with ADDR_W=12, LEN_W=4, DEPTH=4 and TAG_W=8. With a 4 KB mirror, a burst starting at byte 0xFFC crosses the wrap point. An address above 4 KB then aliases back to low memory. Four FIFO entries plus the engine slot let the bench fill the block with five stalled reads. This exposes the back-pressure limit, the write hold-off and in-order draining. The 4-bit length field makes the zero-means-sixteen encoding a short burst.

// File: rtl/mm_resp_pkg.sv
package mm_resp_pkg;
  localparam int DW_W = 32;
  localparam int ST_W = 3;

  typedef enum logic [1:0] {
    REQ_MRD   = 2'd0,
    REQ_MWR   = 2'd1,
    REQ_CFGRD = 2'd2,
    REQ_CFGWR = 2'd3
  } req_kind_e;

  localparam logic [ST_W-1:0] CPL_ST_OK = 3'd0;
endpackage

// File: rtl/mm_pend_fifo.sv
module mm_pend_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full_o  = (count == CW'(DEPTH));
  assign empty_o = (count == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = store[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) store[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mm_mem_mirror.sv
module mm_mem_mirror #(
  parameter int ADDR_W = 12
) (
  input  logic                           clk_i,
  input  logic                           we_i,
  input  logic [ADDR_W-3:0]              widx_i,
  input  logic [mm_resp_pkg::DW_W-1:0]   wdata_i,
  input  logic [ADDR_W-3:0]              ridx_i,
  output logic [mm_resp_pkg::DW_W-1:0]   rdata_o
);
  localparam int WORDS = 1 << (ADDR_W - 2);

  logic [mm_resp_pkg::DW_W-1:0] mem [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[widx_i] <= wdata_i;
  end

  assign rdata_o = mem[ridx_i];
endmodule

// File: rtl/mm_req_ingress.sv
module mm_req_ingress
  import mm_resp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 4,
  parameter int REQ_AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_type_i,
  input  logic [REQ_AW-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [DW_W-1:0]   req_data_i,
  output logic              req_ready_o,
  input  logic              fifo_full_i,
  input  logic              rd_quiet_i,
  output logic              mem_we_o,
  output logic [ADDR_W-3:0] mem_widx_o,
  output logic [DW_W-1:0]   mem_wdata_o,
  output logic              push_o,
  output logic              push_cfg_o,
  output logic              wr_busy_o
);
  localparam int WIDX_W = ADDR_W - 2;

  req_kind_e         kind;
  logic              acc;
  logic              wr_busy;
  logic [WIDX_W-1:0] wr_idx;
  logic [LEN_W:0]    wr_left;
  logic [LEN_W:0]    cnt;
  logic [WIDX_W-1:0] hdr_idx;

  assign kind    = req_kind_e'(req_type_i);
  assign hdr_idx = req_addr_i[ADDR_W-1:2];
  assign cnt     = (req_len_i == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, req_len_i};

  always_comb begin
    if (wr_busy) begin
      req_ready_o = 1'b1;
    end else begin
      unique case (kind)
        REQ_MRD, REQ_CFGRD: req_ready_o = !fifo_full_i;
        REQ_MWR:            req_ready_o = rd_quiet_i;
        default:            req_ready_o = 1'b1;
      endcase
    end
  end

  assign acc         = req_valid_i && req_ready_o;
  assign mem_we_o    = acc && (wr_busy || kind == REQ_MWR);
  assign mem_widx_o  = wr_busy ? wr_idx : hdr_idx;
  assign mem_wdata_o = req_data_i;
  assign push_o      = acc && !wr_busy && (kind == REQ_MRD || kind == REQ_CFGRD);
  assign push_cfg_o  = (kind == REQ_CFGRD);
  assign wr_busy_o   = wr_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_busy <= 1'b0;
      wr_idx  <= '0;
      wr_left <= '0;
    end else if (acc) begin
      if (wr_busy) begin
        wr_idx  <= wr_idx + 1'b1;
        wr_left <= wr_left - 1'b1;
        if (wr_left == (LEN_W+1)'(1)) wr_busy <= 1'b0;
      end else if (kind == REQ_MWR && cnt > (LEN_W+1)'(1)) begin
        wr_busy <= 1'b1;
        wr_idx  <= hdr_idx + 1'b1;
        wr_left <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mm_cpl_engine.sv
module mm_cpl_engine
  import mm_resp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 4,
  parameter int TAG_W  = 8,
  parameter int REQ_AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_i,
  input  logic              head_cfg_i,
  input  logic [TAG_W-1:0]  head_tag_i,
  input  logic [LEN_W-1:0]  head_len_i,
  input  logic [REQ_AW-1:0] head_addr_i,
  output logic              pop_o,
  output logic [ADDR_W-3:0] mem_ridx_o,
  input  logic [DW_W-1:0]   mem_rdata_i,
  output logic              busy_o,
  output logic              cpl_valid_o,
  input  logic              cpl_ready_i,
  output logic [TAG_W-1:0]  cpl_tag_o,
  output logic [LEN_W-1:0]  cpl_len_o,
  output logic [REQ_AW-1:0] cpl_addr_o,
  output logic [DW_W-1:0]   cpl_data_o,
  output logic [ST_W-1:0]   cpl_status_o,
  output logic              cpl_last_o
);
  logic              busy, is_cfg;
  logic [TAG_W-1:0]  tag_q;
  logic [LEN_W-1:0]  len_q;
  logic [REQ_AW-1:0] addr_q;
  logic [ADDR_W-3:0] idx_q;
  logic [LEN_W:0]    left_q;
  logic [LEN_W:0]    head_cnt;
  logic              beat_done;

  assign head_cnt  = (head_len_i == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, head_len_i};
  assign pop_o     = !busy && !fifo_empty_i;
  assign beat_done = busy && cpl_ready_i;

  assign busy_o       = busy;
  assign cpl_valid_o  = busy;
  assign cpl_tag_o    = tag_q;
  assign cpl_len_o    = is_cfg ? LEN_W'(1) : len_q;
  assign cpl_addr_o   = addr_q;
  assign mem_ridx_o   = idx_q;
  assign cpl_data_o   = is_cfg ? '0 : mem_rdata_i;
  assign cpl_status_o = CPL_ST_OK;
  assign cpl_last_o   = (left_q == (LEN_W+1)'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy   <= 1'b0;
      is_cfg <= 1'b0;
      tag_q  <= '0;
      len_q  <= '0;
      addr_q <= '0;
      idx_q  <= '0;
      left_q <= '0;
    end else if (pop_o) begin
      busy   <= 1'b1;
      is_cfg <= head_cfg_i;
      tag_q  <= head_tag_i;
      len_q  <= head_len_i;
      addr_q <= head_addr_i;
      idx_q  <= head_addr_i[ADDR_W-1:2];
      left_q <= head_cfg_i ? (LEN_W+1)'(1) : head_cnt;
    end else if (beat_done) begin
      idx_q  <= idx_q + 1'b1;
      left_q <= left_q - 1'b1;
      if (cpl_last_o) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mm_mirror_responder.sv
module mm_mirror_responder
  import mm_resp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 4,
  parameter int TAG_W  = 8,
  parameter int REQ_AW = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_type_i,
  input  logic [REQ_AW-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [31:0]       req_data_i,
  output logic              cpl_valid_o,
  input  logic              cpl_ready_i,
  output logic [TAG_W-1:0]  cpl_tag_o,
  output logic [LEN_W-1:0]  cpl_len_o,
  output logic [REQ_AW-1:0] cpl_addr_o,
  output logic [31:0]       cpl_data_o,
  output logic [2:0]        cpl_status_o,
  output logic              cpl_last_o
);
  localparam int EW = 1 + TAG_W + LEN_W + REQ_AW;

  logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic              push_cfg, eng_busy, ing_wr_busy, rd_quiet;
  logic [EW-1:0]     fifo_din, fifo_dout;
  logic              mem_we;
  logic [ADDR_W-3:0] mem_widx, mem_ridx;
  logic [DW_W-1:0]   mem_wdata, mem_rdata;
  logic              head_cfg;
  logic [TAG_W-1:0]  head_tag;
  logic [LEN_W-1:0]  head_len;
  logic [REQ_AW-1:0] head_addr;

  assign rd_quiet = fifo_empty && !eng_busy;
  assign fifo_din = {push_cfg, req_tag_i, req_len_i, req_addr_i};
  assign {head_cfg, head_tag, head_len, head_addr} = fifo_dout;

  mm_req_ingress #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REQ_AW(REQ_AW)) u_ingress (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_type_i  (req_type_i),
    .req_addr_i  (req_addr_i),
    .req_len_i   (req_len_i),
    .req_data_i  (req_data_i),
    .req_ready_o (req_ready_o),
    .fifo_full_i (fifo_full),
    .rd_quiet_i  (rd_quiet),
    .mem_we_o    (mem_we),
    .mem_widx_o  (mem_widx),
    .mem_wdata_o (mem_wdata),
    .push_o      (fifo_push),
    .push_cfg_o  (push_cfg),
    .wr_busy_o   (ing_wr_busy)
  );

  mm_pend_fifo #(.W(EW), .DEPTH(DEPTH)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .din_i   (fifo_din),
    .pop_i   (fifo_pop),
    .dout_o  (fifo_dout),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  mm_mem_mirror #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .widx_i  (mem_widx),
    .wdata_i (mem_wdata),
    .ridx_i  (mem_ridx),
    .rdata_o (mem_rdata)
  );

  mm_cpl_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .REQ_AW(REQ_AW)) u_cpl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_empty_i (fifo_empty),
    .head_cfg_i   (head_cfg),
    .head_tag_i   (head_tag),
    .head_len_i   (head_len),
    .head_addr_i  (head_addr),
    .pop_o        (fifo_pop),
    .mem_ridx_o   (mem_ridx),
    .mem_rdata_i  (mem_rdata),
    .busy_o       (eng_busy),
    .cpl_valid_o  (cpl_valid_o),
    .cpl_ready_i  (cpl_ready_i),
    .cpl_tag_o    (cpl_tag_o),
    .cpl_len_o    (cpl_len_o),
    .cpl_addr_o   (cpl_addr_o),
    .cpl_data_o   (cpl_data_o),
    .cpl_status_o (cpl_status_o),
    .cpl_last_o   (cpl_last_o)
  );
endmodule

// File: rtl/mm_responder_checker.sv
module mm_responder_checker #(
  parameter int LEN_W  = 4,
  parameter int TAG_W  = 8,
  parameter int REQ_AW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [1:0]        req_type_i,
  input logic              cpl_valid_o,
  input logic              cpl_ready_i,
  input logic [TAG_W-1:0]  cpl_tag_o,
  input logic [LEN_W-1:0]  cpl_len_o,
  input logic [REQ_AW-1:0] cpl_addr_o,
  input logic [31:0]       cpl_data_o,
  input logic [2:0]        cpl_status_o,
  input logic              cpl_last_o,
  input logic              fifo_push,
  input logic              fifo_full,
  input logic              fifo_empty,
  input logic              eng_busy,
  input logic              ing_wr_busy
);
  logic [LEN_W:0] beat_cnt;
  logic [LEN_W:0] len_dec;

  assign len_dec = (cpl_len_o == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, cpl_len_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_cnt <= '0;
    else if (cpl_valid_o && cpl_ready_i) beat_cnt <= cpl_last_o ? '0 : beat_cnt + 1'b1;
  end

  AST_CPL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o && !cpl_ready_i |=> cpl_valid_o); // R9
  AST_CPL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o && !cpl_ready_i |=> $stable(cpl_tag_o) && $stable(cpl_len_o) &&
      $stable(cpl_addr_o) && $stable(cpl_data_o) && $stable(cpl_last_o)); // R9
  AST_STATUS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o |-> cpl_status_o == 3'd0); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push |-> !fifo_full); // R10
  AST_WR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_type_i == 2'd1 && !ing_wr_busy |-> fifo_empty && !eng_busy); // R11
  AST_LAST_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o && cpl_last_o |-> (LEN_W+1)'(beat_cnt + 1'b1) == len_dec); // R2
  AST_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o && !cpl_last_o |-> (LEN_W+1)'(beat_cnt + 1'b1) < len_dec); // R2
endmodule

bind mm_mirror_responder mm_responder_checker #(
  .LEN_W(LEN_W), .TAG_W(TAG_W), .REQ_AW(REQ_AW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_type_i   (req_type_i),
  .cpl_valid_o  (cpl_valid_o),
  .cpl_ready_i  (cpl_ready_i),
  .cpl_tag_o    (cpl_tag_o),
  .cpl_len_o    (cpl_len_o),
  .cpl_addr_o   (cpl_addr_o),
  .cpl_data_o   (cpl_data_o),
  .cpl_status_o (cpl_status_o),
  .cpl_last_o   (cpl_last_o),
  .fifo_push    (fifo_push),
  .fifo_full    (fifo_full),
  .fifo_empty   (fifo_empty),
  .eng_busy     (eng_busy),
  .ing_wr_busy  (ing_wr_busy)
);

// File: tb/tb_mm_mirror_responder.sv
`timescale 1ns/1ps
module tb_mm_mirror_responder;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = 4;
  localparam int TAG_W  = 8;
  localparam int REQ_AW = 32;
  localparam int DEPTH  = 4;
  localparam int WORDS  = 1 << (ADDR_W - 2);

  localparam logic [1:0] T_MRD = 2'd0, T_MWR = 2'd1, T_CRD = 2'd2, T_CWR = 2'd3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [1:0]        req_type_i = T_MRD;
  logic [REQ_AW-1:0] req_addr_i = '0;
  logic [LEN_W-1:0]  req_len_i = '0;
  logic [TAG_W-1:0]  req_tag_i = '0;
  logic [31:0]       req_data_i = '0;
  logic              cpl_valid_o;
  logic              cpl_ready_i = 1'b0;
  logic [TAG_W-1:0]  cpl_tag_o;
  logic [LEN_W-1:0]  cpl_len_o;
  logic [REQ_AW-1:0] cpl_addr_o;
  logic [31:0]       cpl_data_o;
  logic [2:0]        cpl_status_o;
  logic              cpl_last_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] ref_mem [WORDS];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mm_mirror_responder #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .REQ_AW(REQ_AW), .DEPTH(DEPTH)
  ) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int dec_len(input logic [LEN_W-1:0] l);
    return (l == '0) ? (1 << LEN_W) : int'(l);
  endfunction

  function automatic int widx(input logic [REQ_AW-1:0] a, input int i);
    return (int'(a[ADDR_W-1:2]) + i) % WORDS;
  endfunction

  // one request beat, ok=0 if not accepted within tmo cycles
  task automatic try_beat(input logic [1:0] t, input logic [REQ_AW-1:0] a,
                          input logic [LEN_W-1:0] l, input logic [TAG_W-1:0] g,
                          input logic [31:0] d, input int tmo, output bit ok);
    int w = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_type_i = t; req_addr_i = a;
    req_len_i = l; req_tag_i = g; req_data_i = d;
    #1;
    while (!req_ready_o && w < tmo) begin
      @(negedge clk_i); #1; w++;
    end
    ok = req_ready_o;
    if (ok) @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic mem_write(input logic [REQ_AW-1:0] a, input logic [LEN_W-1:0] l, input int seed);
    bit ok;
    int n = dec_len(l);
    for (int i = 0; i < n; i++) begin
      logic [31:0] d = 32'hA500_0000 ^ (seed << 12) ^ i;
      try_beat(T_MWR, a, l, 8'h00, d, 200, ok);
      if (ok) ref_mem[widx(a, i)] = d;
      else chk("R1 write beat accepted", 0, 1);
    end
  endtask

  task automatic expect_cpl(input string req, input logic [TAG_W-1:0] g,
                            input logic [LEN_W-1:0] l, input logic [REQ_AW-1:0] a, input bit cfg);
    int n = cfg ? 1 : dec_len(l);
    @(negedge clk_i);
    cpl_ready_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      int w = 0;
      #1;
      while (!cpl_valid_o && w < 200) begin
        @(negedge clk_i); #1; w++;
      end
      chk({req, " valid"}, 32'(cpl_valid_o), 1);
      chk({req, " tag"}, 32'(cpl_tag_o), 32'(g));
      chk({req, " len"}, 32'(cpl_len_o), cfg ? 1 : 32'(l));
      chk({req, " addr"}, cpl_addr_o, a);
      chk({req, " data"}, cpl_data_o, cfg ? 32'h0 : ref_mem[widx(a, i)]);
      chk({req, " last"}, 32'(cpl_last_o), 32'(i == n - 1));
      chk("R8 status", 32'(cpl_status_o), 0);
      @(posedge clk_i);
      @(negedge clk_i);
    end
    cpl_ready_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk_i); #1;
    chk("R12 cpl_valid after reset", 32'(cpl_valid_o), 0);
    req_type_i = T_MRD; #1;
    chk("R12 ready after reset", 32'(req_ready_o), 1);
  endtask

  task automatic t_write_read();
    bit ok;
    mem_write(32'h100, 4'd4, 1);
    repeat (5) @(negedge clk_i);
    chk("R1 no completion for write", 32'(cpl_valid_o), 0);
    try_beat(T_MRD, 32'h100, 4'd4, 8'h3d, 0, 50, ok);
    expect_cpl("R2 read", 8'h3d, 4'd4, 32'h100, 0);
    try_beat(T_MRD, 32'h104, 4'd2, 8'h11, 0, 50, ok);
    expect_cpl("R2 offset read", 8'h11, 4'd2, 32'h104, 0);
  endtask

  task automatic t_len_zero();
    bit ok;
    mem_write(32'h200, 4'd0, 2);
    try_beat(T_MRD, 32'h200, 4'd0, 8'h20, 0, 50, ok);
    expect_cpl("R3 zero length read", 8'h20, 4'd0, 32'h200, 0);
  endtask

  task automatic t_wrap();
    bit ok;
    mem_write(32'hFFC, 4'd3, 3);
    try_beat(T_MRD, 32'h0000_0000, 4'd2, 8'h31, 0, 50, ok);
    expect_cpl("R4 wrapped data", 8'h31, 4'd2, 32'h0, 0);
    try_beat(T_MRD, 32'h0000_0FFE, 4'd2, 8'h32, 0, 50, ok);
    expect_cpl("R4 low bits and wrap read", 8'h32, 4'd2, 32'h0000_0FFE, 0);
    try_beat(T_MRD, 32'h0001_1000, 4'd1, 8'h33, 0, 50, ok);
    expect_cpl("R4 high bits alias", 8'h33, 4'd1, 32'h0001_1000, 0);
  endtask

  task automatic t_cfg();
    bit ok;
    try_beat(T_CRD, 32'h100, 4'd4, 8'h77, 0, 50, ok);
    expect_cpl("R5 cfg read", 8'h77, 4'd4, 32'h100, 1);
    try_beat(T_CWR, 32'h100, 4'd1, 8'h78, 32'hDEAD_BEEF, 50, ok);
    chk("R6 cfg write accepted", 32'(ok), 1);
    repeat (3) @(negedge clk_i);
    chk("R6 cfg write no completion", 32'(cpl_valid_o), 0);
    try_beat(T_MRD, 32'h100, 4'd1, 8'h79, 0, 50, ok);
    expect_cpl("R6 memory unchanged", 8'h79, 4'd1, 32'h100, 0);
  endtask

  task automatic t_full_order();
    bit ok;
    int acc = 0;
    logic [TAG_W-1:0] t0;
    logic [31:0] d0;
    for (int k = 0; k < DEPTH + 3; k++) begin
      try_beat(T_MRD, 32'h100, 4'd1, 8'h40 + 8'(k), 0, 20, ok);
      if (ok) acc++;
    end
    chk("R10 reads accepted before stall", acc, DEPTH + 1);
    try_beat(T_CRD, 32'h100, 4'd1, 8'h50, 0, 10, ok);
    chk("R10 cfg read held off when full", 32'(ok), 0);
    try_beat(T_MWR, 32'h100, 4'd1, 8'h00, 32'h1234_5678, 10, ok);
    chk("R11 write held off while reads pending", 32'(ok), 0);
    // R9: stalled completion stays put
    #1;
    t0 = cpl_tag_o; d0 = cpl_data_o;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R9 valid held", 32'(cpl_valid_o), 1);
    chk("R9 tag stable", 32'(cpl_tag_o), 32'(t0));
    chk("R9 data stable", cpl_data_o, d0);
    for (int k = 0; k < DEPTH + 1; k++)
      expect_cpl("R7 in-order drain", 8'h40 + 8'(k), 4'd1, 32'h100, 0);
    try_beat(T_MWR, 32'h100, 4'd1, 8'h00, 32'h1234_5678, 20, ok);
    chk("R11 write accepted once drained", 32'(ok), 1);
    if (ok) ref_mem[widx(32'h100, 0)] = 32'h1234_5678;
    try_beat(T_MRD, 32'h100, 4'd1, 8'h5a, 0, 50, ok);
    expect_cpl("R11 read after write", 8'h5a, 4'd1, 32'h100, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_write_read();
    t_len_zero();
    t_wrap();
    t_cfg();
    t_full_order();
    repeat (5) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule